// File: doc/BRIEF.md
# Baud Tick Generator

This block times the bit clock of a serial port that runs either asynchronously or as the clock master of a synchronous link. An 8-bit period value X is loaded through a write strobe. An 8-bit timer counts from 0 up to X and then starts again, so it produces a base pulse every X+1 clock cycles. A phase counter then divides that base pulse by a factor set by the operating mode. The outputs are single-cycle strobes: a bit-rate tick, a 16x oversample tick for the asynchronous receiver, and a toggle strobe from which the synchronous shift clock is made.

The mode is held in a three-state machine whose states are `MODE_ASYNC_LO` (asynchronous, normal speed), `MODE_ASYNC_HI` (asynchronous, high speed) and `MODE_SYNC_MST` (synchronous master). On every clock the machine moves to the state that the two mode inputs select. The sync input has priority and hides the speed input. Each transition into a different state is a restart, and so is every period write. A restart clears the timer and the phase counter, so the new rate applies from the very next cycle. A re-entry into the same state is not a restart.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted all three outputs stay low. Reset clears the period and the timer to 0 and puts the state machine in `MODE_ASYNC_LO`.
- R2: The timer produces a base pulse every X+1 cycles, where X is the stored period (0..255). With X=255 in high-speed asynchronous mode, the oversample tick comes every 256 cycles and the bit tick every 4096 cycles.
- R3: In `MODE_ASYNC_HI` (sync_mode=0, hi_speed=1), the oversample tick fires every X+1 cycles and the bit tick every 16*(X+1) cycles. Every bit tick coincides with an oversample tick.
- R4: In `MODE_ASYNC_LO` (sync_mode=0, hi_speed=0), the oversample tick fires every 4*(X+1) cycles and the bit tick every 64*(X+1) cycles. `sclk_toggle` stays low in both asynchronous states.
- R5: In `MODE_SYNC_MST` (sync_mode=1), `sclk_toggle` fires every 2*(X+1) cycles, giving a shift clock with a period of 4*(X+1). The bit tick fires every 4*(X+1) cycles, together with every second toggle. `os_tick` stays low.
- R6: A period write restarts the count even when the value is unchanged. Take the clock edge that samples the write strobe as cycle 0. The first strobe of period P then appears in cycle P-1.
- R7: A period of 0 is legal and gives the fastest rate: in `MODE_ASYNC_LO` the bit tick comes every 64 cycles.
- R8: While sync_mode=1, changing hi_speed has no effect. It causes no restart, and the strobes keep their existing schedule.
- R9: A change of state without a write restarts the count with the same cycle-0 timing as R6, using the stored period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_wr | input | 1 | Write strobe for the period value |
| period_wdata | input | 8 | Period value X to store |
| hi_speed | input | 1 | Asynchronous high-speed select (ignored when sync_mode=1) |
| sync_mode | input | 1 | 1 selects the synchronous master, 0 the asynchronous mode |
| bit_tick | output | 1 | One-cycle strobe at the bit rate |
| os_tick | output | 1 | One-cycle strobe at 16x the asynchronous bit rate |
| sclk_toggle | output | 1 | One-cycle strobe at which the synchronous shift clock toggles |

## Verification
The bench targets the cycle on which the first strobe appears after a write or a mode change. A design that skipped the restart, or cleared the counters one cycle late, would show that first tick in the wrong cycle. It rewrites an unchanged period in the middle of a count: a design that restarts only when the value changes would keep the old phase. It flips the speed input while in synchronous mode: a design that did not hide that bit would restart or change rate there. It also covers period 0, period 255, and a reset taken while a non-zero period is stored: a timer off by one at either end, or a period register that reset does not clear, would move every strobe.

// File: rtl/brg_pkg.sv
package brg_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC_LO = 2'd0,
        MODE_ASYNC_HI = 2'd1,
        MODE_SYNC_MST = 2'd2
    } brg_mode_e;

    // base pulses per bit, per mode
    localparam int unsigned BIT_DIV_ASYNC_LO = 64;
    localparam int unsigned BIT_DIV_ASYNC_HI = 16;
    localparam int unsigned BIT_DIV_SYNC     = 4;
    // base pulses per oversample tick at normal speed
    localparam int unsigned OS_DIV_ASYNC_LO  = 4;

    localparam int unsigned PHASE_W = $clog2(BIT_DIV_ASYNC_LO);
    localparam int unsigned OS_SH   = $clog2(OS_DIV_ASYNC_LO);

endpackage

// File: rtl/brg_mode_fsm.sv
module brg_mode_fsm
    import brg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_mode,
    input  logic      hi_speed,
    output brg_mode_e mode_q,
    output logic      mode_chg
);

    brg_mode_e mode_d;

    // next state: sync has priority and masks the speed bit
    always_comb begin
        unique case ({sync_mode, hi_speed})
            2'b00:   mode_d = MODE_ASYNC_LO;
            2'b01:   mode_d = MODE_ASYNC_HI;
            default: mode_d = MODE_SYNC_MST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_ASYNC_LO;
        else        mode_q <= mode_d;
    end

    // a real state transition asks the counters to restart
    always_comb begin
        mode_chg = (mode_d != mode_q);
    end

endmodule

// File: rtl/brg_period_reg.sv
module brg_period_reg #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] period_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  period_q <= '0;
        else if (wr) period_q <= wdata;
    end

endmodule

// File: rtl/brg_timer.sv
module brg_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt_q,
    output logic             base_tick
);

    always_comb begin
        base_tick = (cnt_q == period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart)   cnt_q <= '0;
        else if (base_tick) cnt_q <= '0;
        else                cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/brg_tick_gen.sv
module brg_tick_gen
    import brg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      base_tick,
    input  brg_mode_e mode_q,
    output logic      bit_tick,
    output logic      os_tick,
    output logic      sclk_toggle
);

    localparam logic [PHASE_W-1:0] LAST_LO   = PHASE_W'(BIT_DIV_ASYNC_LO - 1);
    localparam logic [PHASE_W-1:0] LAST_HI   = PHASE_W'(BIT_DIV_ASYNC_HI - 1);
    localparam logic [PHASE_W-1:0] LAST_SYNC = PHASE_W'(BIT_DIV_SYNC - 1);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] last_phase;
    logic               at_last;

    always_comb begin
        unique case (mode_q)
            MODE_ASYNC_LO: last_phase = LAST_LO;
            MODE_ASYNC_HI: last_phase = LAST_HI;
            MODE_SYNC_MST: last_phase = LAST_SYNC;
            default:       last_phase = LAST_LO;
        endcase
        at_last = (phase_q == last_phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         phase_q <= '0;
        else if (restart)   phase_q <= '0;
        else if (base_tick) phase_q <= at_last ? '0 : phase_q + PHASE_W'(1);
    end

    // output decode per state
    always_comb begin
        bit_tick    = 1'b0;
        os_tick     = 1'b0;
        sclk_toggle = 1'b0;
        unique case (mode_q)
            MODE_ASYNC_LO: begin
                bit_tick = base_tick && at_last;
                os_tick  = base_tick && (&phase_q[OS_SH-1:0]);
            end
            MODE_ASYNC_HI: begin
                bit_tick = base_tick && at_last;
                os_tick  = base_tick;
            end
            MODE_SYNC_MST: begin
                bit_tick    = base_tick && at_last;
                sclk_toggle = base_tick && phase_q[0];
            end
            default: begin
                bit_tick = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import brg_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_wdata,
    input  logic             hi_speed,
    input  logic             sync_mode,
    output logic             bit_tick,
    output logic             os_tick,
    output logic             sclk_toggle
);

    brg_mode_e        mode_q;
    logic             mode_chg;
    logic             restart;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] timer_cnt;
    logic             base_tick;

    always_comb begin
        restart = period_wr || mode_chg;
    end

    brg_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .hi_speed  (hi_speed),
        .mode_q    (mode_q),
        .mode_chg  (mode_chg)
    );

    brg_period_reg #(.CNT_W(CNT_W)) u_per (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (period_wr),
        .wdata    (period_wdata),
        .period_q (period_q)
    );

    brg_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .period    (period_q),
        .cnt_q     (timer_cnt),
        .base_tick (base_tick)
    );

    brg_tick_gen u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .base_tick   (base_tick),
        .mode_q      (mode_q),
        .bit_tick    (bit_tick),
        .os_tick     (os_tick),
        .sclk_toggle (sclk_toggle)
    );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_wr,
    input logic             sync_mode,
    input logic             bit_tick,
    input logic             os_tick,
    input logic             sclk_toggle,
    input logic             mode_chg,
    input logic [CNT_W-1:0] period_q,
    input logic [CNT_W-1:0] timer_cnt
);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_quiet_in_reset_r1: assert (!bit_tick && !os_tick && !sclk_toggle)
                else $error("outputs active during reset");
        end
    end

    p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        timer_cnt <= period_q);

    p_bit_with_os_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !sync_mode && !$past(sync_mode)) |-> os_tick);

    p_async_no_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sync_mode) |-> !sclk_toggle);

    p_sync_no_os_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_mode) |-> !os_tick);

    p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> (timer_cnt == '0));

    p_mode_change_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (timer_cnt == '0));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_wr   (period_wr),
    .sync_mode   (sync_mode),
    .bit_tick    (bit_tick),
    .os_tick     (os_tick),
    .sclk_toggle (sclk_toggle),
    .mode_chg    (mode_chg),
    .period_q    (period_q),
    .timer_cnt   (timer_cnt)
);

// File: tb/test_baud_tick_gen.sv
`timescale 1ns/1ps
module test_baud_tick_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       period_wr = 1'b0;
    logic [7:0] period_wdata = 8'd0;
    logic       hi_speed = 1'b0;
    logic       sync_mode = 1'b0;
    logic       bit_tick;
    logic       os_tick;
    logic       sclk_toggle;

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    active = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "";
    int    q_bit[$];
    int    q_os[$];
    int    q_tog[$];
    int    org = 0;
    int    cur_eff = 0;
    int    cur_x = 0;

    baud_tick_gen i_baud_tick_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_wr    (period_wr),
        .period_wdata (period_wdata),
        .hi_speed     (hi_speed),
        .sync_mode    (sync_mode),
        .bit_tick     (bit_tick),
        .os_tick      (os_tick),
        .sclk_toggle  (sclk_toggle)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic cmp(input string nm, input logic act, input bit exp);
        if (act || exp) begin
            n_chk++;
            if (act !== exp) begin
                n_fail++;
                $display("FAIL %s %s at cycle %0d: actual %0b expected %0b",
                         cur_tag, nm, cyc, act, exp);
            end
        end
    endtask

    // monitor: pop scheduled strobes as the design produces them
    always @(negedge clk) begin
        if (active) begin
            bit eb, eo, et;
            eb = (q_bit.size() > 0) && (q_bit[0] == cyc);
            eo = (q_os.size() > 0) && (q_os[0] == cyc);
            et = (q_tog.size() > 0) && (q_tog[0] == cyc);
            cmp("bit_tick", bit_tick, eb);
            cmp("os_tick", os_tick, eo);
            cmp("sclk_toggle", sclk_toggle, et);
            if (eb) void'(q_bit.pop_front());
            if (eo) void'(q_os.pop_front());
            if (et) void'(q_tog.pop_front());
        end
    end

    function automatic int eff(input logic sy, input logic hs);
        return sy ? 2 : (hs ? 1 : 0);
    endfunction

    // driver: apply one configuration and schedule the expected strobes
    task automatic window(input string tag, input bit wr, input int x,
                          input logic sy, input logic hs, input int len);
        int e, t0, d, pb, po, pt;
        @(posedge clk); #1;
        period_wr    = wr;
        period_wdata = 8'(x);
        sync_mode    = sy;
        hi_speed     = hs;
        @(posedge clk); #1;
        t0 = cyc;
        period_wr = 1'b0;
        e = eff(sy, hs);
        if (wr) cur_x = x;
        if (wr || e != cur_eff) org = t0;
        cur_eff = e;
        d = cur_x + 1;
        case (e)
            0:       begin pb = 64 * d; po = 4 * d; pt = 0;     end
            1:       begin pb = 16 * d; po = d;     pt = 0;     end
            default: begin pb = 4 * d;  po = 0;     pt = 2 * d; end
        endcase
        for (int s = t0; s < t0 + len; s++) begin
            if (pb > 0 && ((s - org + 1) % pb) == 0) q_bit.push_back(s);
            if (po > 0 && ((s - org + 1) % po) == 0) q_os.push_back(s);
            if (pt > 0 && ((s - org + 1) % pt) == 0) q_tog.push_back(s);
        end
        cur_tag = tag;
        active = 1'b1;
        repeat (len) @(posedge clk);
        #1;
        active = 1'b0;
        n_chk++;
        if (q_bit.size() + q_os.size() + q_tog.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing strobes: actual %0d left expected 0",
                     tag, q_bit.size() + q_os.size() + q_tog.size());
        end
        q_bit.delete();
        q_os.delete();
        q_tog.delete();
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        period_wr = 1'b0;
        sync_mode = 1'b0;
        hi_speed = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (bit_tick || os_tick || sclk_toggle) begin
            n_fail++;
            $display("FAIL R1 outputs in reset: actual %0b%0b%0b expected 000",
                     bit_tick, os_tick, sclk_toggle);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        cur_eff = 0;
        cur_x = 0;
    endtask

    initial begin
        do_reset();
        window("R1", 1'b0, 0, 1'b0, 1'b1, 40);     // cleared period, mode change to high speed
        window("R4", 1'b1, 3, 1'b0, 1'b0, 600);
        window("R3", 1'b1, 9, 1'b0, 1'b1, 400);
        window("R7", 1'b1, 0, 1'b0, 1'b0, 200);
        window("R5", 1'b1, 5, 1'b1, 1'b0, 120);
        window("R8", 1'b0, 5, 1'b1, 1'b1, 120);    // speed bit flipped in sync
        window("R8", 1'b0, 5, 1'b1, 1'b0, 60);
        window("R6", 1'b1, 9, 1'b0, 1'b1, 7);
        window("R6", 1'b1, 9, 1'b0, 1'b1, 400);    // same value rewritten mid-count
        window("R9", 1'b0, 9, 1'b0, 1'b0, 700);    // hi -> lo without write
        window("R9", 1'b0, 9, 1'b1, 1'b0, 100);    // lo -> sync without write
        window("R2", 1'b1, 255, 1'b0, 1'b1, 4200);
        window("R1", 1'b1, 7, 1'b0, 1'b0, 40);
        do_reset();
        window("R1", 1'b0, 0, 1'b0, 1'b1, 40);     // period must be 0 again
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule